// File: doc/BRIEF.md
# Nested Prioritized Vectored Interrupt Controller

This block sits beside a program sequencer. It collects eleven interrupt sources, picks the most urgent one the current nesting level allows, and offers the sequencer a vector address. Each vector is four program words wide, so a short handler can sit at its vector without a jump. When the sequencer accepts a vector, the block saves the current PC and status word on two small stacks. A return-from-interrupt strobe restores the newest pair and closes the most urgent open service level. Higher-priority sources can interrupt a handler that is already running, to any nesting depth.

Raw request lines pass through a two-flop synchronizer, and a rising edge latches the request as pending. Software can also set a pending bit through a force input. An enable register that software writes gates the maskable sources. A powerdown source bypasses that gate. Every maskable source is disabled after reset.

The vector leaves on a valid/ready interface. An offer is registered. While `vec_valid` is high and `vec_ready` is low, the address stays frozen and no newer, more urgent request replaces it. A vector counts as taken only in a cycle where both signals are high. The restored PC and status come back as a one-cycle `ret_valid` pulse that carries no back-pressure.

Top module: `ivc_nest_ctrl`

## Requirements
- R1: In the first cycle after reset is released, `vec_valid` is high with `vec_addr` = 0x0000 before any request arrives. Taking that vector pushes nothing on the stacks and opens no service level.
- R2: Slots are numbered 1 to 11. Bit i of `irq_raw` belongs to slot i+1, and bit i of `en_wdata` and of `force_set` belongs to slot i+1. The vector is 4 × slot, so slot 11 (powerdown) gives 0x002C. The slot map is: 1 external IRQ2, 2–3 host port, 4–5 serial port 0, 6–7 software, 8 serial port 1 transmit or IRQ1, 9 serial port 1 receive or IRQ0, 10 timer, 11 powerdown.
- R3: Priority is fixed. Powerdown ranks highest, then slot 1 down through slot 10, which ranks lowest. When several sources are pending together, the highest-ranked one is offered first.
- R4: A maskable slot is offered only while its enable bit is 1. A pending request whose enable bit is 0 stays pending and is offered once the bit is set. All enable bits reset to 0. Powerdown ignores the enables.
- R5: A rising edge on a raw line becomes pending after the two-flop synchronizer. Pending is cleared when that vector is taken. A line held high raises no further request.
- R6: A one-cycle pulse on a `force_set` bit makes that slot pending exactly as a hardware request would.
- R7: A request is offered only if it outranks every open service level. A request of equal or lower rank waits until return strobes have closed every level it does not outrank.
- R8: While `vec_valid` is high and `vec_ready` is low, `vec_valid` and `vec_addr` hold. A vector is taken only in a cycle with both signals high.
- R9: Taking a vector with slot 1–11 pushes `pc_i` and `status_i`. On `rti_i` with a non-empty stack, `ret_valid` pulses in the next cycle with the most recently pushed pair (last in, first out), and the highest-ranked open service level closes.
- R10: The stacks hold `STK_DEPTH` entries (4 by default). Taking a vector while they are full pulses `stk_ovf` for one cycle after the take. The push is discarded and the take still proceeds.
- R11: `rti_i` with empty stacks leaves `ret_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_raw | input | 11 | Asynchronous request lines, bit i for slot i+1 |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 10 | Enable bits for slots 1–10, 1 = enabled |
| force_set | input | 10 | Software force pulses for slots 1–10 |
| pc_i | input | PC_W | Current PC, pushed on take |
| status_i | input | ST_W | Current status word, pushed on take |
| rti_i | input | 1 | Return-from-interrupt strobe |
| vec_valid | output | 1 | Vector offer valid |
| vec_ready | input | 1 | Sequencer accepts the vector |
| vec_addr | output | PC_W | Vector address, 4 × slot |
| ret_valid | output | 1 | Restored pair valid, one-cycle pulse |
| ret_pc | output | PC_W | Restored PC |
| ret_status | output | ST_W | Restored status word |
| stk_ovf | output | 1 | Push attempted on full stacks |

## Verification
The hardest state to reach from the ports is a full stack with nested levels open, followed by unwinding past the point where stack depth and nesting depth no longer match. Software force pulses build five nested levels in rising rank order. The bench then parks a lower-ranked request behind them and unwinds with return strobes. It checks that the parked request appears only after the level it does not outrank has closed, and that the final return sees an empty stack.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int unsigned N_LINE = 11;          // slots 1..11
  localparam int unsigned N_MSK  = 10;          // maskable slots 1..10
  localparam int unsigned SLOT_W = 4;
  localparam logic [SLOT_W-1:0] PD_SLOT = 4'd11;
  localparam logic [SLOT_W-1:0] BOOT_SLOT = 4'd0;

  // rank 0 is powerdown, rank r (1..10) is slot r
  function automatic logic [SLOT_W-1:0] slot_rank(input logic [SLOT_W-1:0] s);
    return (s == PD_SLOT) ? '0 : s;
  endfunction

  function automatic logic [SLOT_W-1:0] rank_slot(input logic [SLOT_W-1:0] r);
    return (r == '0) ? PD_SLOT : r;
  endfunction
endpackage

// File: rtl/ivc_req_sync.sv
module ivc_req_sync #(
  parameter int unsigned N      = 11,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic [STAGES:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], raw[i]};
    end
    assign rise[i] = sh[STAGES-1] & ~sh[STAGES];
  end
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter #(
  parameter int unsigned N  = 11,
  localparam int unsigned RW = $clog2(N)
) (
  input  logic [N-1:0]  req_rank,
  input  logic [N-1:0]  isr_rank,
  output logic          hit,
  output logic [RW-1:0] win
);
  logic          any_req, any_isr;
  logic [RW-1:0] isr_top;

  always_comb begin
    any_req = 1'b0;
    any_isr = 1'b0;
    win     = '0;
    isr_top = '0;
    for (int r = N - 1; r >= 0; r--) begin
      if (req_rank[r]) begin
        any_req = 1'b1;
        win     = RW'(r);
      end
      if (isr_rank[r]) begin
        any_isr = 1'b1;
        isr_top = RW'(r);
      end
    end
    hit = any_req & (~any_isr | (win < isr_top));
  end
endmodule

// File: rtl/ivc_lifo.sv
module ivc_lifo #(
  parameter int unsigned W     = 14,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt;
  logic          do_pop, do_push, do_swap;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_pop  = pop & ~empty;
  assign do_swap = push & do_pop;
  assign do_push = push & ~pop & ~full;
  assign top     = mem[AW'(cnt - 1'b1)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (do_push) cnt <= cnt + 1'b1;
    else if (do_pop && !do_swap) cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_swap)      mem[AW'(cnt - 1'b1)] <= din;
    else if (do_push) mem[AW'(cnt)]        <= din;
  end
endmodule

// File: rtl/ivc_nest_ctrl.sv
module ivc_nest_ctrl
  import ivc_pkg::*;
#(
  parameter int unsigned PC_W        = 14,
  parameter int unsigned ST_W        = 8,
  parameter int unsigned STK_DEPTH   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_LINE-1:0] irq_raw,
  input  logic              en_we,
  input  logic [N_MSK-1:0]  en_wdata,
  input  logic [N_MSK-1:0]  force_set,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [ST_W-1:0]   status_i,
  input  logic              rti_i,
  output logic              vec_valid,
  input  logic              vec_ready,
  output logic [PC_W-1:0]   vec_addr,
  output logic              ret_valid,
  output logic [PC_W-1:0]   ret_pc,
  output logic [ST_W-1:0]   ret_status,
  output logic              stk_ovf
);
  localparam int unsigned RW = $clog2(N_LINE);

  logic [N_MSK-1:0]  en_q;
  logic [N_LINE-1:0] pend_q, isr_q, rise, elig_rank, take_line, take_rank_oh;
  logic              off_valid;
  logic [SLOT_W-1:0] off_slot;
  logic              hit, take, take_irq;
  logic [RW-1:0]     win;
  logic [PC_W-1:0]   pc_top;
  logic [ST_W-1:0]   st_top;
  logic              pc_empty, pc_full, st_empty, st_full;

  ivc_req_sync #(.N(N_LINE), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(irq_raw), .rise(rise)
  );

  // eligible requests laid out by rank
  assign elig_rank[0] = pend_q[N_LINE-1];
  for (genvar r = 1; r < N_LINE; r++) begin : g_elig
    assign elig_rank[r] = pend_q[r-1] & en_q[r-1];
  end

  ivc_arbiter #(.N(N_LINE)) u_arb (
    .req_rank(elig_rank), .isr_rank(isr_q), .hit(hit), .win(win)
  );

  assign take         = off_valid & vec_ready;
  assign take_irq     = take & (off_slot != BOOT_SLOT);
  assign take_line    = take_irq ? (N_LINE'(1) << (off_slot - 1'b1)) : '0;
  assign take_rank_oh = take_irq ? (N_LINE'(1) << slot_rank(off_slot)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      isr_q  <= '0;
    end else begin
      if (en_we) en_q <= en_wdata;
      pend_q <= (pend_q & ~take_line) | rise | {1'b0, force_set};
      isr_q  <= (rti_i ? (isr_q & (isr_q - 1'b1)) : isr_q) | take_rank_oh;
    end
  end

  // registered offer, frozen under back-pressure
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_valid <= 1'b1;
      off_slot  <= BOOT_SLOT;
    end else if (take) begin
      off_valid <= 1'b0;
    end else if (!off_valid && hit) begin
      off_valid <= 1'b1;
      off_slot  <= rank_slot(SLOT_W'(win));
    end
  end

  assign vec_valid = off_valid;
  assign vec_addr  = PC_W'(off_slot) << 2;

  ivc_lifo #(.W(PC_W), .DEPTH(STK_DEPTH)) u_pc_stk (
    .clk(clk), .rst_n(rst_n), .push(take_irq), .pop(rti_i), .din(pc_i),
    .top(pc_top), .empty(pc_empty), .full(pc_full)
  );

  ivc_lifo #(.W(ST_W), .DEPTH(STK_DEPTH)) u_st_stk (
    .clk(clk), .rst_n(rst_n), .push(take_irq), .pop(rti_i), .din(status_i),
    .top(st_top), .empty(st_empty), .full(st_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_valid  <= 1'b0;
      ret_pc     <= '0;
      ret_status <= '0;
      stk_ovf    <= 1'b0;
    end else begin
      ret_valid <= rti_i & ~pc_empty;
      stk_ovf   <= take_irq & pc_full & ~rti_i;
      if (rti_i && !pc_empty) begin
        ret_pc     <= pc_top;
        ret_status <= st_top;
      end
    end
  end

  logic unused_flags;
  assign unused_flags = st_empty ^ st_full;
endmodule

// File: rtl/ivc_nest_chk.sv
module ivc_nest_chk #(
  parameter int unsigned PC_W = 14
) (
  input logic            clk,
  input logic            rst_n,
  input logic            vec_valid,
  input logic            vec_ready,
  input logic [PC_W-1:0] vec_addr,
  input logic            rti_i,
  input logic            ret_valid,
  input logic            stk_ovf,
  input logic [9:0]      en_q
);
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_addr[1:0] == 2'b00 && vec_addr <= PC_W'(44))); // R2

  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_addr))); // R8

  AST_RET_AFTER_RTI: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> $past(rti_i)); // R9

  AST_OVF_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf |-> $past(vec_valid && vec_ready)); // R10

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !$past(vec_valid) && vec_addr != '0 && vec_addr != PC_W'(44))
      |-> ((($past(en_q)) >> (vec_addr[5:2] - 4'd1)) & 10'd1) != 10'd0); // R4
endmodule

bind ivc_nest_ctrl ivc_nest_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_ready(vec_ready),
  .vec_addr(vec_addr), .rti_i(rti_i), .ret_valid(ret_valid),
  .stk_ovf(stk_ovf), .en_q(en_q)
);

// File: tb/sim_ivc_nest_ctrl.sv
module sim_ivc_nest_ctrl;
  localparam int PC_W = 14;
  localparam int ST_W = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [10:0]     irq_raw = '0;
  logic            en_we = 1'b0;
  logic [9:0]      en_wdata = '0;
  logic [9:0]      force_set = '0;
  logic [PC_W-1:0] pc_i = '0;
  logic [ST_W-1:0] status_i = '0;
  logic            rti_i = 1'b0;
  logic            vec_valid, vec_ready, ret_valid, stk_ovf;
  logic [PC_W-1:0] vec_addr, ret_pc;
  logic [ST_W-1:0] ret_status;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  assign vec_ready = rdy;
  logic rdy = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ivc_nest_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .en_we(en_we),
    .en_wdata(en_wdata), .force_set(force_set), .pc_i(pc_i),
    .status_i(status_i), .rti_i(rti_i), .vec_valid(vec_valid),
    .vec_ready(vec_ready), .vec_addr(vec_addr), .ret_valid(ret_valid),
    .ret_pc(ret_pc), .ret_status(ret_status), .stk_ovf(stk_ovf)
  );

  // {req[9:0] for slots 1..10, first slot, second slot (15 = none)}
  localparam logic [17:0] TBL [6] = '{
    {10'b00_0000_0100, 4'd3,  4'd15},
    {10'b10_0000_0001, 4'd1,  4'd10},
    {10'b00_0100_1000, 4'd4,  4'd7},
    {10'b01_1000_0000, 4'd8,  4'd9},
    {10'b00_0011_0000, 4'd5,  4'd6},
    {10'b00_0000_0010, 4'd2,  4'd15}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic take();
    @(negedge clk); rdy = 1'b1;
    @(negedge clk); rdy = 1'b0;
  endtask

  task automatic do_rti();
    @(negedge clk); rti_i = 1'b1;
    @(negedge clk); rti_i = 1'b0;
  endtask

  task automatic set_en(input logic [9:0] v);
    @(negedge clk); en_we = 1'b1; en_wdata = v;
    @(negedge clk); en_we = 1'b0;
  endtask

  task automatic force_pulse(input int slot);
    @(negedge clk); force_set = 10'(1) << (slot - 1);
    @(negedge clk); force_set = '0;
  endtask

  task automatic wait_offer(input int lim, output bit got);
    got = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (vec_valid) begin got = 1'b1; break; end
    end
  endtask

  task automatic expect_offer(input int slot, input string req);
    bit got;
    wait_offer(20, got);
    check(got && vec_addr == PC_W'(slot * 4), req, got ? int'(vec_addr) : -1, slot * 4);
  endtask

  task automatic expect_quiet(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      seen |= vec_valid;
    end
    check(!seen, req, int'(seen), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog R1..R11 run hung actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    bit got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 boot vector, R8 back-pressure
    @(negedge clk);
    check(vec_valid && vec_addr == '0, "R1", int'(vec_addr), 0);
    check(!ret_valid && !stk_ovf, "R1", int'({ret_valid, stk_ovf}), 0);
    repeat (3) @(negedge clk);
    check(vec_valid && vec_addr == '0, "R8", int'({vec_valid, vec_addr}), 1 << PC_W);
    take();
    do_rti();
    check(!ret_valid, "R1", int'(ret_valid), 0);

    // R4 masked after reset, then enabled; R5 held line
    irq_raw[2] = 1'b1;
    expect_quiet(10, "R4");
    set_en(10'b00_0000_0100);
    expect_offer(3, "R4");
    take();
    do_rti();
    expect_quiet(10, "R5");
    irq_raw = '0;
    repeat (5) @(negedge clk);

    // table walk: R3 order, R7 lower waits, R5 edge requests
    set_en('1);
    foreach (TBL[k]) begin
      irq_raw[9:0] = TBL[k][17:8];
      expect_offer(int'(TBL[k][7:4]), "R3");
      take();
      if (TBL[k][3:0] != 4'd15) begin
        expect_quiet(8, "R7");
        do_rti();
        expect_offer(int'(TBL[k][3:0]), "R3");
        take();
        do_rti();
      end else begin
        do_rti();
        expect_quiet(8, "R5");
      end
      irq_raw = '0;
      repeat (5) @(negedge clk);
    end

    // R6 software force
    force_pulse(7);
    expect_offer(7, "R6");
    take();
    do_rti();

    // R2 powerdown ignores enables; R9 pair restored
    set_en('0);
    pc_i = 14'h123; status_i = 8'h5A;
    irq_raw[10] = 1'b1;
    expect_offer(11, "R2");
    take();
    do_rti();
    check(ret_valid && ret_pc == 14'h123, "R9", int'(ret_pc), 'h123);
    check(ret_status == 8'h5A, "R9", int'(ret_status), 'h5A);
    irq_raw = '0;
    repeat (5) @(negedge clk);

    // nesting to overflow: R7, R10, R9 LIFO, R11
    set_en('1);
    for (int k = 0; k < 4; k++) begin
      pc_i = PC_W'(14'h100 + k); status_i = ST_W'(8'h10 + k);
      force_pulse(10 - k);
      expect_offer(10 - k, "R7");
      take();
      check(!stk_ovf, "R10", int'(stk_ovf), 0);
    end
    force_pulse(9);
    expect_quiet(10, "R7");
    pc_i = 14'h1FF; status_i = 8'hFF;
    force_pulse(6);
    expect_offer(6, "R7");
    take();
    check(stk_ovf, "R10", int'(stk_ovf), 1);
    @(negedge clk);
    check(!stk_ovf, "R10", int'(stk_ovf), 0);
    for (int k = 3; k >= 0; k--) begin
      do_rti();
      check(ret_valid && ret_pc == PC_W'(14'h100 + k), "R9", int'(ret_pc), 'h100 + k);
      check(ret_status == ST_W'(8'h10 + k), "R9", int'(ret_status), 'h10 + k);
      if (k > 0) check(!vec_valid, "R7", int'(vec_valid), 0);
    end
    expect_offer(9, "R7");
    pc_i = 14'h0AB; status_i = 8'h3C;
    take();
    do_rti();
    check(ret_valid && ret_pc == 14'h0AB && ret_status == 8'h3C, "R9", int'(ret_pc), 'hAB);
    do_rti();
    check(!ret_valid, "R11", int'(ret_valid), 0);
    expect_quiet(6, "R11");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule